// File: doc/BRIEF.md
# Converter Serial Port Slave

This block models the digital serial port of a sigma-delta converter. The port is a mode-3 style slave: SCLK idles high, DIN is taken on the rising edge, and output bits change on the falling edge. A single output pin, `dout_rdy`, carries two things. While a register word is being shifted out it carries that word. At all other times it carries the not-ready flag, which is low while an unread conversion result is waiting. Every access starts with a command byte. That byte names one register and says whether it is read or written. The registers are an 8-bit status register, a 16-bit control register, a 24-bit data register and a fixed 8-bit identity register. A one-cycle `conv_done` strobe stores a new result and its channel number.

The control register sets three read options. With continuous read, results are streamed out with no command byte, and an in-band command ends the stream. With status append, the status byte follows every data word. With framing, chip select must frame each read. Any other control bits are only stored, and they are presented on `ctrl_word`. A run of 64 ones on DIN returns the whole port to its reset state.

SCLK, CS_N and DIN are sampled by the system clock `clk`. Each SCLK edge takes effect at the first `clk` rising edge that sees it.

Top module: `convif_port`

## Requirements
- R1: After reset, `dout_rdy` is 1 (no unread result) and `ctrl_word` is 0.
- R2: The command byte is shifted in MSB first. Bit 6 set means read and bit 6 clear means write, and bits 5:0 hold the address. The addresses are 0 for status, 1 for control, 2 for data and 5 for identity. Reading address 5 returns 8'h5A.
- R3: A write to address 1 takes 16 bits, MSB first. Bits 15:13 are always stored as zero, and `ctrl_word` shows the stored value.
- R4: Writes to the status, data and identity registers change nothing. Reading them back returns their earlier contents.
- R5: A `conv_done` pulse stores `conv_data` and `conv_chan` and drives the not-ready flag low. The status register holds the not-ready flag in bit 7 and the channel in bits 3:0.
- R6: A data read returns 24 bits, MSB first. Output bits change on SCLK falling edges and DIN is taken on SCLK rising edges. Completing a data read sets the not-ready flag to 1.
- R7: With control bit 10 set, each data read returns 32 bits: the 24 data bits followed by the status byte.
- R8: With control bit 9 clear, `dout_rdy` shows the not-ready flag again once the last SCLK rising edge of a read has passed. With bit 9 set, it holds the word's LSB until CS_N goes high.
- R9: With control bit 11 set, a data read puts the port into stream mode. In stream mode, each SCLK burst that starts while the flag is low shifts out the data word, with no command byte.
- R10: In stream mode, if the first 8 DIN bits of a streamed word are 8'h42, control bit 11 is cleared and the port expects a command byte again.
- R11: 64 consecutive ones on DIN, counted on SCLK rising edges, reset every register and the state to the reset values. A single zero restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data in |
| conv_done | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data | input | 24 | Conversion result stored on `conv_done` |
| conv_chan | input | 4 | Channel of the result stored on `conv_done` |
| dout_rdy | output | 1 | Shared pin: serial data out, or the not-ready flag |
| ctrl_word | output | 16 | Stored control register |

## Verification
Each SCLK edge takes effect at the first `clk` rising edge after the edge. So an output bit is valid one `clk` after a falling edge, and the pin shows the ready flag one `clk` after the last rising edge of a read. A `conv_done` pulse moves the flag on the next clock. The 64-ones reset lands on the same clock as the 64th rising edge. The bench changes SCLK, CS_N and DIN on falling `clk` edges. After each change it waits two full clock periods and then samples, so every result has been registered at least one edge earlier.

// File: rtl/convif_pkg.sv
package convif_pkg;

  typedef enum logic [2:0] {
    ST_CMD    = 3'd0,
    ST_WRITE  = 3'd1,
    ST_READ   = 3'd2,
    ST_HOLD   = 3'd3,
    ST_STREAM = 3'd4
  } port_state_e;

  localparam logic [5:0] ADR_STAT = 6'd0;
  localparam logic [5:0] ADR_CTRL = 6'd1;
  localparam logic [5:0] ADR_DATA = 6'd2;
  localparam logic [5:0] ADR_ID   = 6'd5;

  localparam int BIT_RD     = 6;
  localparam int BIT_FRAME  = 9;
  localparam int BIT_APPEND = 10;
  localparam int BIT_CONT   = 11;

  localparam logic [7:0] CMD_READ_DATA = 8'h42;

endpackage

// File: rtl/convif_edges.sv
module convif_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b1;
    else        sclk_q <= sclk;
  end

  assign rise = !cs_n &&  sclk && !sclk_q;
  assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/convif_ones_watch.sv
module convif_ones_watch #(
  parameter int RUN_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic din,
  output logic hit
);
  localparam int RW = $clog2(RUN_LEN);
  localparam logic [RW-1:0] LAST = RW'(RUN_LEN - 1);

  logic [RW-1:0] run_q, run_d;

  assign hit = rise && din && (run_q == LAST);

  always_comb begin
    run_d = run_q;
    if (rise) begin
      if (!din || hit) run_d = '0;
      else             run_d = run_q + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R11: a zero on DIN restarts the run count
  a_r11_zero_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !din) |=> (run_q == '0));
endmodule

// File: rtl/convif_word_mux.sv
module convif_word_mux
  import convif_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CTRL_W = 16,
  parameter int STAT_W = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [5:0]        addr,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] data,
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] id,
  input  logic              append,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  len
);
  always_comb begin
    word = '0;
    len  = CNT_W'(STAT_W);
    case (addr)
      ADR_STAT: word = {stat, {(WORD_W-STAT_W){1'b0}}};
      ADR_ID:   word = {id,   {(WORD_W-STAT_W){1'b0}}};
      ADR_CTRL: begin
        word = {ctrl, {(WORD_W-CTRL_W){1'b0}}};
        len  = CNT_W'(CTRL_W);
      end
      ADR_DATA: begin
        if (append) begin
          word = {data, stat};
          len  = CNT_W'(DATA_W + STAT_W);
        end else begin
          word = {data, {STAT_W{1'b0}}};
          len  = CNT_W'(DATA_W);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/convif_port.sv
module convif_port
  import convif_pkg::*;
#(
  parameter int         DATA_W  = 24,
  parameter int         CTRL_W  = 16,
  parameter int         STAT_W  = 8,
  parameter int         CHAN_W  = 4,
  parameter int         RUN_LEN = 64,
  parameter logic [7:0] ID_VAL  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan,
  output logic              dout_rdy,
  output logic [CTRL_W-1:0] ctrl_word
);
  localparam int WORD_W = DATA_W + STAT_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] BYTE7 = CNT_W'(7);
  localparam logic [CTRL_W-1:0] CTRL_MASK = {3'b000, {(CTRL_W-3){1'b1}}};

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic rise, fall, ones_hit;

  convif_edges u_edges (
    .clk(clk), .rst_n(rst_s_n), .sclk(sclk), .cs_n(cs_n),
    .rise(rise), .fall(fall)
  );

  convif_ones_watch #(.RUN_LEN(RUN_LEN)) u_ones (
    .clk(clk), .rst_n(rst_s_n), .rise(rise), .din(din), .hit(ones_hit)
  );

  port_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, len_q, len_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CTRL_W-1:0] in_q, in_d, ctrl_q, ctrl_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [5:0]        addr_q, addr_d;
  logic              obit_q, obit_d, cont_q, cont_d, rdyn_q, rdyn_d;

  logic [7:0]        byte_v;
  logic [5:0]        mux_addr;
  logic [STAT_W-1:0] stat_v;
  logic [WORD_W-1:0] mux_word;
  logic [CNT_W-1:0]  mux_len;

  assign byte_v   = {in_q[6:0], din};
  assign mux_addr = (st_q == ST_STREAM) ? ADR_DATA : byte_v[5:0];
  assign stat_v   = {rdyn_q, {(STAT_W-1-CHAN_W){1'b0}}, chan_q};

  convif_word_mux #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .STAT_W(STAT_W),
    .WORD_W(WORD_W), .CNT_W(CNT_W)
  ) u_mux (
    .addr(mux_addr), .ctrl(ctrl_q), .data(data_q), .stat(stat_v),
    .id(STAT_W'(ID_VAL)), .append(ctrl_q[BIT_APPEND]),
    .word(mux_word), .len(mux_len)
  );

  always_comb begin
    st_d = st_q;     cnt_d = cnt_q;   len_d = len_q;   sh_d = sh_q;
    in_d = in_q;     ctrl_d = ctrl_q; data_d = data_q; chan_d = chan_q;
    addr_d = addr_q; obit_d = obit_q; cont_d = cont_q; rdyn_d = rdyn_q;
    if (cs_n) begin
      st_d  = cont_q ? ST_STREAM : ST_CMD;
      cnt_d = '0;
    end else begin
      if (fall) begin
        if (st_q == ST_READ) begin
          obit_d = sh_q[WORD_W-1];
          sh_d   = sh_q << 1;
        end else if (st_q == ST_STREAM && !rdyn_q) begin
          obit_d = mux_word[WORD_W-1];
          sh_d   = mux_word << 1;
          len_d  = mux_len;
          addr_d = ADR_DATA;
          cnt_d  = '0;
          st_d   = ST_READ;
        end
      end
      if (rise) begin
        in_d = {in_q[CTRL_W-2:0], din};
        case (st_q)
          ST_CMD: begin
            cnt_d = cnt_q + ONE;
            if (cnt_q == BYTE7) begin
              cnt_d  = '0;
              addr_d = byte_v[5:0];
              len_d  = mux_len;
              if (byte_v[BIT_RD]) begin
                st_d   = ST_READ;
                sh_d   = mux_word;
                obit_d = mux_word[WORD_W-1];
              end else begin
                st_d = ST_WRITE;
              end
            end
          end
          ST_WRITE: begin
            cnt_d = cnt_q + ONE;
            if (cnt_q + ONE == len_q) begin
              if (addr_q == ADR_CTRL) ctrl_d = in_d & CTRL_MASK;
              cnt_d = '0;
              st_d  = ST_CMD;
            end
          end
          ST_READ: begin
            cnt_d = cnt_q + ONE;
            if (cont_q && cnt_q == BYTE7 && byte_v == CMD_READ_DATA) begin
              ctrl_d[BIT_CONT] = 1'b0;
              cont_d = 1'b0;
            end
            if (cnt_q + ONE == len_q) begin
              cnt_d = '0;
              if (addr_q == ADR_DATA) begin
                rdyn_d = 1'b1;
                cont_d = ctrl_d[BIT_CONT];
              end
              if (ctrl_q[BIT_FRAME]) st_d = ST_HOLD;
              else if (cont_d)       st_d = ST_STREAM;
              else                   st_d = ST_CMD;
            end
          end
          default: ;
        endcase
      end
    end
    if (conv_done) begin
      data_d = conv_data;
      chan_d = conv_chan;
      rdyn_d = 1'b0;
    end
    if (ones_hit) begin
      st_d = ST_CMD; cnt_d = '0; len_d = '0; ctrl_d = '0; data_d = '0;
      chan_d = '0; cont_d = 1'b0; rdyn_d = 1'b1; obit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_CMD; cnt_q <= '0; len_q <= '0; sh_q <= '0; in_q <= '0;
      ctrl_q <= '0; data_q <= '0; chan_q <= '0; addr_q <= '0;
      obit_q <= 1'b1; cont_q <= 1'b0; rdyn_q <= 1'b1;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; len_q <= len_d; sh_q <= sh_d; in_q <= in_d;
      ctrl_q <= ctrl_d; data_q <= data_d; chan_q <= chan_d; addr_q <= addr_d;
      obit_q <= obit_d; cont_q <= cont_d; rdyn_q <= rdyn_d;
    end
  end

  assign dout_rdy  = (st_q == ST_READ || st_q == ST_HOLD) ? obit_q : rdyn_q;
  assign ctrl_word = ctrl_q;

  // R5: a finished conversion pulls the flag low on the next clock
  a_r5_conv_sets_ready: assert property (@(posedge clk) disable iff (!rst_s_n)
    (conv_done && !ones_hit) |=> !rdyn_q);

  // R11: the ones run restores the reset values
  a_r11_run_resets: assert property (@(posedge clk) disable iff (!rst_s_n)
    ones_hit |=> (ctrl_q == '0 && !cont_q && rdyn_q && st_q == ST_CMD));

  // R9: waiting for a streamed word only while stream mode is on
  a_r9_stream_needs_cont: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_STREAM) |-> cont_q);

  // R6: the bit count never passes the word length during a read
  a_r6_count_in_word: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_READ) |-> (cnt_q < len_q));
endmodule

// File: tb/convif_port_bench.sv
`timescale 1ns/1ps
module convif_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        conv_done = 1'b0;
  logic [23:0] conv_data = '0;
  logic [3:0]  conv_chan = '0;
  logic        dout_rdy;
  logic [15:0] ctrl_word;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  convif_port u_convif_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .conv_done(conv_done), .conv_data(conv_data), .conv_chan(conv_chan),
    .dout_rdy(dout_rdy), .ctrl_word(ctrl_word)
  );

  typedef struct packed {
    logic [7:0]  cmd;
    logic [5:0]  nb;
    logic [31:0] tx;
    logic [31:0] exp;
    logic        chk;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h45, 6'd8,  32'h0,      32'h5A,   1'b1, 4'd2},  // R2 identity read
    '{8'h01, 6'd16, 32'hE0C3,   32'h0,    1'b0, 4'd3},  // R3 control write
    '{8'h41, 6'd16, 32'h0,      32'h00C3, 1'b1, 4'd3},  // R3 top bits zero
    '{8'h05, 6'd8,  32'hFF,     32'h0,    1'b0, 4'd4},  // R4 write identity
    '{8'h45, 6'd8,  32'h0,      32'h5A,   1'b1, 4'd4},  // R4 identity kept
    '{8'h00, 6'd8,  32'hFF,     32'h0,    1'b0, 4'd4},  // R4 write status
    '{8'h40, 6'd8,  32'h0,      32'h80,   1'b1, 4'd4},  // R4 status kept
    '{8'h02, 6'd24, 32'hABCDEF, 32'h0,    1'b0, 4'd4},  // R4 write data
    '{8'h42, 6'd24, 32'h0,      32'h0,    1'b1, 4'd4},  // R4 data kept
    '{8'h01, 6'd16, 32'h0,      32'h0,    1'b0, 4'd3},  // R3 clear control
    '{8'h41, 6'd16, 32'h0,      32'h0,    1'b1, 4'd3}   // R3 read back zero
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int nb, input logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      @(negedge clk); din = tx[i]; sclk = 1'b0;
      repeat (2) @(negedge clk);
      rx[i] = dout_rdy;
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    din = 1'b0;
  endtask

  task automatic cs_lo();
    @(negedge clk); cs_n = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic cs_hi();
    @(negedge clk); cs_n = 1'b1; repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] cmd, input int nb, input logic [31:0] tx,
                       output logic [31:0] rx);
    logic [31:0] junk;
    cs_lo();
    xfer(8, {24'h0, cmd}, junk);
    xfer(nb, tx, rx);
    cs_hi();
  endtask

  task automatic conv(input logic [23:0] d, input logic [3:0] ch);
    @(negedge clk); conv_done = 1'b1; conv_data = d; conv_chan = ch;
    @(negedge clk); conv_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rx;
    logic [31:0] junk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 pin after reset", {31'h0, dout_rdy}, 32'h1);
    check("R1 control after reset", {16'h0, ctrl_word}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      frame(VECS[v].cmd, int'(VECS[v].nb), VECS[v].tx, rx);
      if (VECS[v].chk)
        check($sformatf("R%0d vector %0d", VECS[v].req, v), rx, VECS[v].exp);
    end

    // R5 and R6: conversion, status, data read
    conv(24'h123456, 4'd3);
    check("R5 flag low after conversion", {31'h0, dout_rdy}, 32'h0);
    frame(8'h40, 8, 32'h0, rx);
    check("R5 status byte", rx, 32'h03);
    cs_lo();
    xfer(8, 32'h42, junk);
    xfer(24, 32'h0, rx);
    check("R6 data word", rx, 32'h123456);
    repeat (2) @(negedge clk);
    check("R8 free pin shows ready after read (R6 flag high)", {31'h0, dout_rdy}, 32'h1);
    cs_hi();

    // R8 framed read holds LSB
    frame(8'h01, 16, 32'h0200, junk);
    conv(24'hA5A5A4, 4'd1);
    cs_lo();
    xfer(8, 32'h42, junk);
    xfer(24, 32'h0, rx);
    check("R8 framed data word", rx, 32'hA5A5A4);
    repeat (2) @(negedge clk);
    check("R8 LSB held while selected", {31'h0, dout_rdy}, 32'h0);
    cs_hi();
    check("R8 ready after deselect", {31'h0, dout_rdy}, 32'h1);

    // R7 status appended
    frame(8'h01, 16, 32'h0400, junk);
    conv(24'h00FF01, 4'd5);
    frame(8'h42, 32, 32'h0, rx);
    check("R7 data plus status", rx, 32'h00FF0105);

    // R9 and R10 continuous read
    frame(8'h01, 16, 32'h0800, junk);
    conv(24'h111111, 4'd2);
    cs_lo();
    xfer(8, 32'h42, junk);
    xfer(24, 32'h0, rx);
    check("R9 first word by command", rx, 32'h111111);
    check("R9 flag high after read", {31'h0, dout_rdy}, 32'h1);
    conv(24'h222222, 4'd2);
    xfer(24, 32'h0, rx);
    check("R9 streamed word", rx, 32'h222222);
    check("R9 control bit kept", {16'h0, ctrl_word}, 32'h0800);
    conv(24'h333333, 4'd2);
    xfer(24, 32'h420000, rx);
    check("R10 word during exit", rx, 32'h333333);
    check("R10 control bit cleared", {16'h0, ctrl_word}, 32'h0);
    xfer(8, 32'h45, junk);
    xfer(8, 32'h0, rx);
    check("R10 command mode again", rx, 32'h5A);
    cs_hi();

    // R11 run of ones
    frame(8'h01, 16, 32'h0400, junk);
    conv(24'h0ABCDE, 4'd0);
    cs_lo();
    xfer(32, 32'hFFFFFFFF, junk);
    xfer(32, 32'hFFFFFFFE, junk);
    cs_hi();
    check("R11 63 ones keep control", {16'h0, ctrl_word}, 32'h0400);
    check("R11 63 ones keep flag", {31'h0, dout_rdy}, 32'h0);
    cs_lo();
    xfer(32, 32'hFFFFFFFF, junk);
    xfer(32, 32'hFFFFFFFF, junk);
    cs_hi();
    check("R11 64 ones clear control", {16'h0, ctrl_word}, 32'h0);
    check("R11 64 ones clear flag", {31'h0, dout_rdy}, 32'h1);

    summary();
    $finish;
  end
endmodule